// File: doc/BRIEF.md
# Vector Rounding Halving Adder

This block averages two 128-bit SIMD operand vectors lane by lane and rounds each average upward. A 2-bit lane-size code splits the vectors into 16, 8, 4 or 2 lanes. A mode input selects two's-complement or unsigned treatment. A width input decides whether the whole 128-bit result is used or only its lower 64 bits, with the upper half cleared.

The average is never formed from a sum one bit wider than the lane. Each element is first halved by a shift inside its lane. A one-bit rounding term, derived from the two dropped low bits, is then added. All additions stay inside the lane, so no carry crosses a lane boundary.

The result is registered once under a clock enable. A separate flag marks the one unsupported setting: a single 64-bit lane in the half-width case. The result value for that setting carries no meaning.

Top module: `rhadd_vec`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first enabled edge, `sum_avg` is all zeros and `bad_combo` is 0.
- R2: With `op_unsigned`=1, each lane of `sum_avg` equals floor((a+b+1)/2), where a and b are the lane's elements read as unsigned integers.
- R3: With `op_unsigned`=0, each lane of `sum_avg` equals floor((a+b+1)/2), where a and b are read as two's-complement integers. The result is written in two's complement. Extreme values are included (most negative, most positive, all ones).
- R4: `lane_size` code 0, 1, 2 and 3 selects lane widths of 8, 16, 32 and 64 bits. Lane k occupies bits [k*w+w-1 : k*w].
- R5: A lane's result depends only on the same lane of both operands. No carry or sign propagates into a neighbouring lane.
- R6: With `full_width`=0, bits 127:64 of `sum_avg` are zero and bits 63:0 carry the lane results. With `full_width`=1, all 128 bits carry lane results.
- R7: `bad_combo` is 1 exactly when the last enabled sample had `full_width`=0 and `lane_size`=3. Otherwise it is 0.
- R8: Inputs are sampled on a rising `clk` edge with `en`=1, and the outputs show the result right after that edge. On an edge with `en`=0, both outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the result registers |
| op_unsigned | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| full_width | input | 1 | 1 = 128-bit result, 0 = lower 64 bits only |
| lane_size | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64 bits) |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector |
| sum_avg | output | 128 | Registered per-lane rounded averages |
| bad_combo | output | 1 | Unsupported setting flag |

## Verification
For 8-bit lanes, every pair of byte values is applied in both modes. This separates rounding-up from truncation, and logical from arithmetic halving, over the full value range. Per-lane patterns of all ones, sign bit only, and maximum positive are applied at every lane size, together with mixed-sign and random vectors. A carry or sign leaking between lanes shows up as an error in the neighbouring lane. Half-width runs at every size show whether the upper bits are cleared and whether the unsupported flag rises only for 64-bit lanes. Enable-low cycles with changed inputs show whether the outputs hold their values.

// File: rtl/rhadd_pkg.sv
package rhadd_pkg;
  localparam int VEC_W      = 128;
  localparam int NUM_SIZES  = 4;
  localparam int MIN_LANE_W = 8;

  typedef enum logic [1:0] {
    LSZ_8  = 2'd0,
    LSZ_16 = 2'd1,
    LSZ_32 = 2'd2,
    LSZ_64 = 2'd3
  } lane_sz_e;
endpackage

// File: rtl/rhadd_lane.sv
module rhadd_lane #(
  parameter int W = 8
) (
  input  logic         sgn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W-1:0] a_half;
  logic [W-1:0] b_half;
  logic [1:0]   rnd_sum;
  logic [W-1:0] rnd_bit;

  always_comb begin
    a_half  = {sgn & a[W-1], a[W-1:1]};
    b_half  = {sgn & b[W-1], b[W-1:1]};
    rnd_sum = {1'b0, a[0]} + {1'b0, b[0]} + 2'd1;
    rnd_bit = W'(rnd_sum[1]);
    y       = a_half + b_half + rnd_bit;
  end
endmodule

// File: rtl/rhadd_half.sv
module rhadd_half
  import rhadd_pkg::*;
#(
  parameter int HW = 64
) (
  input  logic          sgn,
  input  lane_sz_e      size,
  input  logic [HW-1:0] a,
  input  logic [HW-1:0] b,
  output logic [HW-1:0] y
);
  logic [NUM_SIZES-1:0][HW-1:0] per_size;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = MIN_LANE_W << s;
    localparam int NL = HW / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      rhadd_lane #(.W(LW)) u_lane (
        .sgn (sgn),
        .a   (a[l*LW +: LW]),
        .b   (b[l*LW +: LW]),
        .y   (per_size[s][l*LW +: LW])
      );
    end
  end

  always_comb begin
    y = per_size[size];
  end
endmodule

// File: rtl/rhadd_ctrl.sv
module rhadd_ctrl
  import rhadd_pkg::*;
(
  input  lane_sz_e size,
  input  logic     full_width,
  output logic     keep_upper,
  output logic     illegal
);
  always_comb begin
    keep_upper = full_width;
    illegal    = ~full_width & (size == LSZ_64);
  end
endmodule

// File: rtl/rhadd_vec.sv
module rhadd_vec
  import rhadd_pkg::*;
#(
  parameter int DATA_W = VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              op_unsigned,
  input  logic              full_width,
  input  logic [1:0]        lane_size,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] sum_avg,
  output logic              bad_combo
);
  localparam int HALF_W = DATA_W / 2;

  lane_sz_e          size_e;
  logic              keep_upper;
  logic              illegal_d;
  logic [DATA_W-1:0] raw_avg;
  logic [DATA_W-1:0] avg_d;
  logic [DATA_W-1:0] avg_q;
  logic              bad_q;

  assign size_e = lane_sz_e'(lane_size);

  rhadd_ctrl u_ctrl (
    .size       (size_e),
    .full_width (full_width),
    .keep_upper (keep_upper),
    .illegal    (illegal_d)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    rhadd_half #(.HW(HALF_W)) u_half (
      .sgn  (~op_unsigned),
      .size (size_e),
      .a    (src_a[h*HALF_W +: HALF_W]),
      .b    (src_b[h*HALF_W +: HALF_W]),
      .y    (raw_avg[h*HALF_W +: HALF_W])
    );
  end

  always_comb begin
    avg_d = raw_avg;
    if (!keep_upper) avg_d[DATA_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q <= '0;
      bad_q <= 1'b0;
    end else if (en) begin
      avg_q <= avg_d;
      bad_q <= illegal_d;
    end
  end

  assign sum_avg   = avg_q;
  assign bad_combo = bad_q;

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !full_width) |=> (sum_avg[DATA_W-1:HALF_W] == '0));

  // R7
  illegal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !full_width && lane_size == 2'd3) |=> bad_combo);

  // R7
  illegal_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (full_width || lane_size != 2'd3)) |=> !bad_combo);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(sum_avg) && $stable(bad_combo)));
endmodule

// File: tb/rhadd_vec_tb_top.sv
module rhadd_vec_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic         op_unsigned;
  logic         full_width;
  logic [1:0]   lane_size;
  logic [127:0] src_a;
  logic [127:0] src_b;
  logic [127:0] sum_avg;
  logic         bad_combo;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  rhadd_vec dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .op_unsigned(op_unsigned),
    .full_width(full_width), .lane_size(lane_size), .src_a(src_a),
    .src_b(src_b), .sum_avg(sum_avg), .bad_combo(bad_combo)
  );

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] sz, input logic uns,
                                         input logic full);
    logic [127:0] r;
    int w;
    int n;
    r = '0;
    w = 8 << sz;
    n = 128 / w;
    for (int i = 0; i < n; i++) begin
      logic [65:0] mask, ea, eb, s;
      mask = (66'd1 << w) - 66'd1;
      ea = 66'((a >> (i*w))) & mask;
      eb = 66'((b >> (i*w))) & mask;
      if (!uns && ea[w-1]) ea = ea | ~mask;
      if (!uns && eb[w-1]) eb = eb | ~mask;
      s = ea + eb + 66'd1;
      r = r | (128'((s >> 1) & mask) << (i*w));
    end
    if (!full) r[127:64] = '0;
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, result visible after next posedge, checked at following negedge
  task automatic run(input string req, input logic [127:0] a, input logic [127:0] b,
                     input logic [1:0] sz, input logic uns, input logic full);
    src_a = a; src_b = b; lane_size = sz; op_unsigned = uns; full_width = full; en = 1'b1;
    @(negedge clk);
    check(req, sum_avg, model(a, b, sz, uns, full));
    check("R7", {127'd0, bad_combo}, {127'd0, (!full && sz == 2'd3)});
  endtask

  function automatic logic [127:0] rep(input logic [1:0] sz, input logic [63:0] lane);
    logic [127:0] r;
    int w;
    r = '0;
    w = 8 << sz;
    for (int i = 0; i < 128 / w; i++)
      r = r | (128'(lane & ((64'd1 << w) - 64'd1)) << (i*w));
    if (sz == 2'd3) r = {lane, lane};
    return r;
  endfunction

  initial begin
    rst_n = 1'b0; en = 1'b0; op_unsigned = 1'b1; full_width = 1'b1;
    lane_size = 2'd0; src_a = '1; src_b = '1;
    repeat (3) @(negedge clk);
    check("R1", sum_avg, '0);
    check("R1", {127'd0, bad_combo}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", sum_avg, '0);

    // R2 R3: exhaustive byte pairs, 16 distinct b values per vector
    for (int m = 0; m < 2; m++) begin
      for (int av = 0; av < 256; av++) begin
        for (int bb = 0; bb < 16; bb++) begin
          logic [127:0] va, vb;
          for (int l = 0; l < 16; l++) begin
            va[l*8 +: 8] = 8'(av);
            vb[l*8 +: 8] = 8'(bb*16 + l);
          end
          run(m == 0 ? "R2" : "R3", va, vb, 2'd0, m == 0, 1'b1);
        end
      end
    end

    // R4 R5 R3: corner patterns at every size, both modes and widths
    for (int sz = 0; sz < 4; sz++) begin
      for (int m = 0; m < 2; m++) begin
        for (int f = 0; f < 2; f++) begin
          logic [63:0] msb, maxp;
          logic [1:0] s2;
          s2 = 2'(sz);
          msb  = 64'd1 << ((8 << sz) - 1);
          maxp = msb - 64'd1;
          run("R4", '1, '1, s2, m == 1, f == 1);
          run("R3", rep(s2, msb), rep(s2, msb), s2, m == 1, f == 1);
          run("R3", rep(s2, maxp), rep(s2, maxp), s2, m == 1, f == 1);
          run("R3", rep(s2, msb), rep(s2, maxp), s2, m == 1, f == 1);
          run("R5", rep(s2, maxp), rep(s2, 64'd1), s2, m == 1, f == 1);
          run("R5", rep(s2, msb), '1, s2, m == 1, f == 1);
          run("R6", '1, 128'd1, s2, m == 1, f == 1);
          for (int r = 0; r < 200; r++)
            run("R4", {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom}, s2, m == 1, f == 1);
        end
      end
    end

    // R8: enable low holds outputs
    run("R8", 128'h1234, 128'h5678, 2'd1, 1'b1, 1'b1);
    begin
      logic [127:0] held;
      held = sum_avg;
      en = 1'b0; src_a = '1; src_b = 128'd0; full_width = 1'b0; lane_size = 2'd3;
      @(negedge clk); @(negedge clk);
      check("R8", sum_avg, held);
      check("R8", {127'd0, bad_combo}, 128'd0);
      en = 1'b1;
      @(negedge clk);
      check("R8", sum_avg, model('1, 128'd0, 2'd3, 1'b1, 1'b0));
      check("R7", {127'd0, bad_combo}, 128'd1);
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule